// File: doc/BRIEF.md
# Message Object Control and Interrupt Logic

This block keeps one control byte for each message object of a CAN controller, for up to fifteen objects. Each control byte holds four flags: object valid, transmit interrupt enable, receive interrupt enable and interrupt pending. Every flag is stored as a true/complement bit pair. Because of this, one register write can set some flags, clear others and leave the rest alone, and software never needs a read-modify-write.

The framing logic reports completed transfers as event pulses. Each pulse carries an object index and a direction flag (transmit or receive). When an event qualifies, it latches that object's pending flag. A qualifying event needs three things: the object is valid, the enable for the event's direction is set, and the global interrupt enable is set. A separate pulse reports that a valid frame was seen on the bus. When the status interrupt enable is set, this pulse latches a status flag, whether or not any object took the frame. A single interrupt request line is the OR of all latched flags.

The global enables come from the main control register, which lives outside this block. Software reads each control byte back through the same register bus.

Top module: `mobj_ctrl_irq`

## Requirements
- R1: After reset every flag is clear. Each object address reads 8'h55, address 0 reads 8'h01 and `irq` is low.
- R2: A control byte has its pairs at bits 7:6 (object valid), 5:4 (transmit enable), 3:2 (receive enable) and 1:0 (pending). Object k sits at address k, for k from 1 to 15. A written pair of 2'b10 sets its flag and 2'b01 clears it, one clock after the write strobe.
- R3: A written pair of 2'b00 or 2'b11 leaves its flag unchanged, while other pairs in the same write still act.
- R4: Reads are combinational. Each pair reads 2'b10 when its flag is set and 2'b01 when it is clear.
- R5: A transmit event (`evt_tx`=1) sets the pending flag of a valid object whose transmit enable is set. A receive event (`evt_tx`=0) does the same using the receive enable. The enable for the other direction has no effect.
- R6: An event is ignored when `gie` is low, when the object's valid flag is clear, or when the object's enable for that direction is clear.
- R7: A `frame_ok` pulse with `sie` high sets the status flag, which reads as bits 1:0 of address 0, whatever the object flags are. Writing 2'b01 to those bits clears it. Bits 7:2 of address 0 read as zero and ignore writes. With `sie` low, `frame_ok` has no effect.
- R8: If a hardware set of a pending flag and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R9: `irq` is high whenever any pending flag or the status flag is set, and it stays high until software clears every one of them. A reception into an object with its receive enable set, arriving while `sie` is high, latches two separate requests: the object's pending flag and the status flag.
- R10: Writes to addresses above 15 change nothing, and such addresses read 8'h00. Events with index 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address: 0 is the status pair, 1..15 are the objects |
| bus_wdata | input | 8 | Write data in paired-bit format |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable from the main control register |
| sie | input | 1 | Status interrupt enable from the main control register |
| evt_valid | input | 1 | One-cycle pulse: a transfer completed |
| evt_idx | input | 4 | Object index of the completed transfer |
| evt_tx | input | 1 | Direction of the transfer: 1 transmit, 0 receive |
| frame_ok | input | 1 | One-cycle pulse: a valid frame was seen on the bus |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the four pair codes on each field. A design that mixed up the keep codes would corrupt neighbouring flags during partial writes.

It drives a hardware set and a software clear into the same pending pair in the same cycle. A design with the wrong priority would lose a completion.

It crosses the global enable, the valid flag and both direction enables. A direction mix-up would raise requests on receive for objects that are meant to transmit.

It fires the reception and the valid-frame pulse together, expecting two requests that software clears one at a time. It also writes to out-of-range addresses and sends events with index 0, to catch decoders that alias onto object 0 or wrap around.

// File: rtl/mobj_pkg.sv
package mobj_pkg;

  localparam int NFLD   = 4;
  localparam int CTRL_W = 2 * NFLD;

  localparam int FLD_PEND = 0;
  localparam int FLD_RXIE = 1;
  localparam int FLD_TXIE = 2;
  localparam int FLD_VAL  = 3;

  typedef enum logic [1:0] {
    PC_KEEP_LO = 2'b00,
    PC_CLEAR   = 2'b01,
    PC_SET     = 2'b10,
    PC_KEEP_HI = 2'b11
  } pair_code_e;

  function automatic logic pair_next(input logic cur, input logic [1:0] code);
    logic nxt;
    case (pair_code_e'(code))
      PC_SET:   nxt = 1'b1;
      PC_CLEAR: nxt = 1'b0;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic [1:0] pair_enc(input logic v);
    return {v, ~v};
  endfunction

endpackage

// File: rtl/mobj_flag.sv
module mobj_flag
  import mobj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  input  logic       hw_set,
  output logic       q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (wr_en)  q <= pair_next(q, wr_code);
  end

  AST_SET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_code == 2'b10 |=> q); // R2
  AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_code == 2'b01 && !hw_set |=> !q); // R2
  AST_KEEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_code == 2'b00 || wr_code == 2'b11) && !hw_set |=> $stable(q)); // R3
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q); // R8

endmodule

// File: rtl/mobj_slot.sv
module mobj_slot
  import mobj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_byte,
  input  logic              set_pend,
  output logic [CTRL_W-1:0] rd_byte,
  output logic              obj_val,
  output logic              obj_txie,
  output logic              obj_rxie,
  output logic              obj_pend
);

  logic [NFLD-1:0] flag_q;
  logic [NFLD-1:0] flag_hw;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    if (f == FLD_PEND) begin : g_hw
      assign flag_hw[f] = set_pend;
    end else begin : g_sw
      assign flag_hw[f] = 1'b0;
    end

    mobj_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_code (wr_byte[2*f+1:2*f]),
      .hw_set  (flag_hw[f]),
      .q       (flag_q[f])
    );

    assign rd_byte[2*f+1:2*f] = pair_enc(flag_q[f]);
  end

  assign obj_val  = flag_q[FLD_VAL];
  assign obj_txie = flag_q[FLD_TXIE];
  assign obj_rxie = flag_q[FLD_RXIE];
  assign obj_pend = flag_q[FLD_PEND];

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    obj_pend && !wr_en |=> obj_pend); // R9

endmodule

// File: rtl/mobj_evt_dec.sv
module mobj_evt_dec #(
  parameter int NUM_OBJ = 15,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic               evt_tx,
  input  logic               gie,
  input  logic [NUM_OBJ-1:0] obj_val,
  input  logic [NUM_OBJ-1:0] obj_txie,
  input  logic [NUM_OBJ-1:0] obj_rxie,
  output logic [NUM_OBJ-1:0] evt_hit,
  output logic [NUM_OBJ-1:0] set_pend
);

  always_comb begin
    for (int k = 0; k < NUM_OBJ; k++) begin
      evt_hit[k]  = evt_valid && (evt_idx == IDX_W'(k + 1));
      set_pend[k] = evt_hit[k] && gie && obj_val[k] &&
                    (evt_tx ? obj_txie[k] : obj_rxie[k]);
    end
  end

  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_pend)); // R5
  AST_SET_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> set_pend == '0); // R6
  AST_IDX0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_idx == '0 |-> evt_hit == '0); // R10

endmodule

// File: rtl/mobj_ctrl_irq.sv
module mobj_ctrl_irq
  import mobj_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              gie,
  input  logic              sie,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic              evt_tx,
  input  logic              frame_ok,
  output logic              irq
);

  logic [NUM_OBJ-1:0] obj_sel;
  logic               sts_sel;
  logic               wr_hit_any;
  logic [NUM_OBJ-1:0] obj_val, obj_txie, obj_rxie, obj_pend;
  logic [NUM_OBJ-1:0] evt_hit, set_pend;
  logic [CTRL_W-1:0]  obj_byte [NUM_OBJ];
  logic               sts_set;
  logic               sts_q;

  always_comb begin
    for (int k = 0; k < NUM_OBJ; k++) begin
      obj_sel[k] = bus_addr == ADDR_W'(k + 1);
    end
  end
  assign sts_sel    = bus_addr == '0;
  assign wr_hit_any = sts_sel || (obj_sel != '0);

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
    mobj_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && obj_sel[k]),
      .wr_byte  (bus_wdata),
      .set_pend (set_pend[k]),
      .rd_byte  (obj_byte[k]),
      .obj_val  (obj_val[k]),
      .obj_txie (obj_txie[k]),
      .obj_rxie (obj_rxie[k]),
      .obj_pend (obj_pend[k])
    );
  end

  mobj_evt_dec #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_idx   (evt_idx),
    .evt_tx    (evt_tx),
    .gie       (gie),
    .obj_val   (obj_val),
    .obj_txie  (obj_txie),
    .obj_rxie  (obj_rxie),
    .evt_hit   (evt_hit),
    .set_pend  (set_pend)
  );

  assign sts_set = frame_ok && sie;

  mobj_flag u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && sts_sel),
    .wr_code (bus_wdata[1:0]),
    .hw_set  (sts_set),
    .q       (sts_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (sts_sel) bus_rdata[1:0] = pair_enc(sts_q);
    for (int k = 0; k < NUM_OBJ; k++) begin
      if (obj_sel[k]) bus_rdata = bus_rdata | obj_byte[k];
    end
  end

  assign irq = sts_q || (obj_pend != '0);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !irq); // R1
  AST_STATUS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && sie |=> irq); // R7
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !bus_we |=> irq); // R9
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !wr_hit_any && !evt_valid && !frame_ok |=> $stable(irq)); // R10

endmodule

// File: tb/tb_mobj_ctrl_irq.sv
module tb_mobj_ctrl_irq;

  localparam int NOBJ = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0, sie = 1'b0;
  logic       evt_valid = 1'b0;
  logic [3:0] evt_idx = '0;
  logic       evt_tx = 1'b0;
  logic       frame_ok = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit [NOBJ:1] m_val, m_tx, m_rx, m_pend;
  bit          m_sts;

  always #5 clk = ~clk;

  mobj_ctrl_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .gie(gie), .sie(sie),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_tx(evt_tx),
    .frame_ok(frame_ok), .irq(irq)
  );

  function automatic bit apply_code(bit cur, logic [1:0] c);
    if (c == 2'b10) return 1'b1;
    if (c == 2'b01) return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (a == 0) return {6'b0, m_sts, ~m_sts};
    if (a >= 1 && a <= NOBJ)
      return {m_val[a], ~m_val[a], m_tx[a], ~m_tx[a],
              m_rx[a], ~m_rx[a], m_pend[a], ~m_pend[a]};
    return 8'h00;
  endfunction

  function automatic bit exp_irq();
    return m_sts || (m_pend != '0);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_chk(string req, int a);
    bus_addr = 5'(a);
    #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  task automatic irq_chk(string req);
    #1;
    chk(req, {7'b0, irq}, {7'b0, exp_irq()});
  endtask

  // one clock: drive at a falling edge, model the rising edge, return at the next falling edge
  task automatic step(bit we, int a, logic [7:0] wd, bit ev, int idx, bit tx, bit fok);
    bit [NOBJ:1] o_val, o_tx, o_rx;
    @(negedge clk);
    bus_we = we; bus_addr = 5'(a); bus_wdata = wd;
    evt_valid = ev; evt_idx = 4'(idx); evt_tx = tx; frame_ok = fok;
    o_val = m_val; o_tx = m_tx; o_rx = m_rx;
    @(negedge clk);
    if (we && a >= 1 && a <= NOBJ) begin
      m_val[a]  = apply_code(m_val[a],  wd[7:6]);
      m_tx[a]   = apply_code(m_tx[a],   wd[5:4]);
      m_rx[a]   = apply_code(m_rx[a],   wd[3:2]);
      m_pend[a] = apply_code(m_pend[a], wd[1:0]);
    end
    if (we && a == 0) m_sts = apply_code(m_sts, wd[1:0]);
    if (ev && idx >= 1 && idx <= NOBJ && gie && o_val[idx] && (tx ? o_tx[idx] : o_rx[idx]))
      m_pend[idx] = 1'b1;
    if (fok && sie) m_sts = 1'b1;
    bus_we = 1'b0; evt_valid = 1'b0; frame_ok = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] wd);
    step(1'b1, a, wd, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 18; a++) rd_chk("R1", a);
    irq_chk("R1");

    // R2 R3 R4 every pair code on every field of object 1
    for (int f = 0; f < 4; f++) begin
      wr(1, 8'(2'b10) << (2*f));
      rd_chk("R2", 1);
      wr(1, 8'(2'b11) << (2*f));
      rd_chk("R3", 1);
      wr(1, 8'h00);
      rd_chk("R3", 1);
      wr(1, 8'(2'b01) << (2*f));
      rd_chk("R2", 1);
      wr(1, 8'hFF);
      rd_chk("R4", 1);
    end
    wr(1, 8'h55);
    rd_chk("R4", 1);
    irq_chk("R2");

    // R5 R6 gating
    gie = 1'b1;
    wr(3, 8'b10_10_01_00);
    step(1'b0, 0, 8'h0, 1'b1, 3, 1'b0, 1'b0);
    rd_chk("R5", 3); irq_chk("R5");
    gie = 1'b0;
    step(1'b0, 0, 8'h0, 1'b1, 3, 1'b1, 1'b0);
    rd_chk("R6", 3); irq_chk("R6");
    gie = 1'b1;
    step(1'b0, 0, 8'h0, 1'b1, 3, 1'b1, 1'b0);
    rd_chk("R5", 3); irq_chk("R5");
    wr(3, 8'h01);
    irq_chk("R9");
    wr(3, 8'h40);
    step(1'b0, 0, 8'h0, 1'b1, 3, 1'b1, 1'b0);
    rd_chk("R6", 3); irq_chk("R6");
    wr(4, 8'b10_01_10_00);
    step(1'b0, 0, 8'h0, 1'b1, 4, 1'b1, 1'b0);
    rd_chk("R6", 4);
    step(1'b0, 0, 8'h0, 1'b1, 4, 1'b0, 1'b0);
    rd_chk("R5", 4); irq_chk("R5");
    wr(4, 8'h01);

    // R7 status flag
    sie = 1'b0;
    step(1'b0, 0, 8'h0, 1'b0, 0, 1'b0, 1'b1);
    rd_chk("R7", 0); irq_chk("R7");
    sie = 1'b1;
    step(1'b0, 0, 8'h0, 1'b0, 0, 1'b0, 1'b1);
    rd_chk("R7", 0); irq_chk("R7");
    wr(0, 8'hFD);
    rd_chk("R7", 0); irq_chk("R7");

    // R9 double request from one reception
    wr(5, 8'b10_00_10_00);
    step(1'b0, 0, 8'h0, 1'b1, 5, 1'b0, 1'b1);
    rd_chk("R9", 5); rd_chk("R9", 0); irq_chk("R9");
    wr(5, 8'h01);
    irq_chk("R9");
    wr(0, 8'h01);
    irq_chk("R9");

    // R8 hardware set beats same-cycle clear
    wr(5, 8'b00_10_00_00);
    step(1'b1, 5, 8'h01, 1'b1, 5, 1'b1, 1'b0);
    rd_chk("R8", 5); irq_chk("R8");
    wr(5, 8'h01);

    // R10 out of range and index 0
    wr(16, 8'hAA); wr(31, 8'h9A);
    for (int a = 0; a < 18; a++) rd_chk("R10", a);
    rd_chk("R10", 31);
    step(1'b0, 0, 8'h0, 1'b1, 0, 1'b1, 1'b0);
    step(1'b0, 0, 8'h0, 1'b1, 0, 1'b0, 1'b0);
    irq_chk("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit we, ev, tx, fok;
      int a, idx;
      we  = ($urandom % 3) == 0;
      a   = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 17);
      ev  = ($urandom % 3) == 0;
      idx = $urandom % 16;
      tx  = $urandom % 2;
      fok = ($urandom % 8) == 0;
      gie = ($urandom % 5) != 0;
      sie = ($urandom % 3) == 0;
      step(we, a, 8'($urandom), ev, idx, tx, fok);
      irq_chk("R9");
      rd_chk("R5", $urandom % 18);
    end

    done = 1'b1;
    finish_run();
  end

endmodule